// File: doc/BRIEF.md
# CPU Low-Power State Controller

This block tracks the power state of a small processor subsystem: running, halted or stopped. Software moves it out of running by writing one byte to a power-control register. A single control bit in that byte selects halt or stop. The interrupt controller's enable and flag vectors decide when the block wakes. A halted core wakes on any enabled, raised interrupt. A stopped core wakes only on the sources that a wake-mask parameter allows.

The controller treats each clock cycle as one step and arbitrates that step between a DMA engine and the CPU. DMA work takes precedence over the CPU and over the wake handling. The block drives three outputs from this arbitration: a CPU clock-enable, an interrupt-take strobe, and a per-step cycle credit for the timer block. A peripheral-enable output pauses the video and sound domains while the subsystem is stopped.

Top module: `cpu_power_ctrl`

## Requirements
- R1: After reset the state output is running, and `periph_en` is 1. The state codes are running = 0, halt = 1 and stop = 2.
- R2: A write (`hc_wr` = 1) moves the state, on the next clock edge, to stop when bit 7 of `hc_wdata` is 1 and to halt when that bit is 0. This holds in every state.
- R3: `hc_rdata` always reads zero.
- R4: While `dma_active` is 1, `cpu_clk_en`, `cpu_irq_take` and `cycle_credit` are all zero, and the state does not change unless a write occurs in the same cycle.
- R5: In running with no DMA, `cpu_clk_en` is 1 and `cycle_credit` equals `cpu_step_cycles`. `cpu_irq_take` is 1 whenever `irq_en & irq_flag` is nonzero.
- R6: In halt with no DMA and `irq_en & irq_flag` equal to zero, `cpu_clk_en` is 0 and `cycle_credit` is exactly 1. The state stays halt.
- R7: In halt with no DMA, no write and `irq_en & irq_flag` nonzero, the controller wakes within the same step. `cpu_irq_take` and `cpu_clk_en` are 1, `cycle_credit` equals `cpu_step_cycles`, and the next state is running.
- R8: In stop without a wake, `periph_en`, `cpu_clk_en` and `cycle_credit` are all 0.
- R9: Stop wakes, with the same outputs as R7, only when `irq_en & irq_flag & WAKE_MASK` is nonzero. Raised interrupts outside the mask leave the state at stop.
- R10: When a write and a pending interrupt occur in the same cycle, the write wins. In that cycle `cpu_irq_take` is 0, and the outputs follow the current state as if nothing were pending. The wake test applies from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hc_wr | input | 1 | Write strobe for the power-control register |
| hc_wdata | input | 8 | Write data; bit 7 selects stop (1) or halt (0) |
| hc_rdata | output | 8 | Read data of the power-control register, always zero |
| irq_en | input | IRQ_W | Interrupt enable vector |
| irq_flag | input | IRQ_W | Interrupt flag vector |
| dma_active | input | 1 | DMA engine owns this step |
| cpu_step_cycles | input | CRED_W | Cycles the CPU reports for this step |
| cpu_clk_en | output | 1 | CPU executes this step |
| cpu_irq_take | output | 1 | CPU takes the pending interrupt this step |
| periph_en | output | 1 | Video and sound domains enabled |
| cycle_credit | output | CRED_W | Cycle credit passed to the timers for this step |
| pwr_state | output | 2 | Current state code |

## Verification
The bench builds the block with IRQ_W = 4 and WAKE_MASK = 4'b0101. With these values, all 256 pairs of enable and flag vectors can be swept in every state, each with DMA both idle and busy. The narrow mask makes pending interrupts outside the mask easy to produce, so the difference between the halt wake rule and the stop wake rule shows up in many cases. Separate directed steps cover writes that coincide with pending interrupts, writes during DMA, and the zero read-back.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_HALT = 2'd1,
    PWR_STOP = 2'd2
  } pwr_state_e;

  // Per-step arbitration result
  typedef struct packed {
    logic exec;
    logic take;
    logic wake;
  } step_ctl_t;

  // Credit handed to the timers for one step
  function automatic logic [7:0] step_credit(input logic dma, input logic exec,
                                             input pwr_state_e st,
                                             input logic [7:0] cpu_cyc);
    if (dma)                 return 8'd0;
    else if (exec)           return cpu_cyc;
    else if (st == PWR_HALT) return 8'd1;
    else                     return 8'd0;
  endfunction

  // Decode of a control write
  function automatic pwr_state_e write_target(input logic stop_sel);
    return stop_sel ? PWR_STOP : PWR_HALT;
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int          IRQ_W     = 14,
  parameter logic [IRQ_W-1:0] WAKE_MASK = '1
) (
  input  logic [IRQ_W-1:0] irq_en,
  input  logic [IRQ_W-1:0] irq_flag,
  output logic             pend_all,
  output logic             pend_wake
);
  logic [IRQ_W-1:0] hit;
  logic [IRQ_W-1:0] hit_wake;

  assign hit = irq_en & irq_flag;

  // Per-source gating; unmasked sources are dropped at elaboration
  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    if (WAKE_MASK[i]) begin : g_keep
      assign hit_wake[i] = hit[i];
    end else begin : g_drop
      assign hit_wake[i] = 1'b0;
    end
  end

  assign pend_all  = |hit;
  assign pend_wake = |hit_wake;
endmodule

// File: rtl/pwr_step_arbiter.sv
module pwr_step_arbiter
  import pwr_pkg::*;
#(
  parameter int CRED_W = 8
) (
  input  pwr_state_e        state,
  input  logic              dma_active,
  input  logic              hc_wr,
  input  logic              pend_all,
  input  logic              pend_wake,
  input  logic [CRED_W-1:0] cpu_step_cycles,
  output step_ctl_t         ctl,
  output logic [CRED_W-1:0] credit,
  output logic              periph_en
);
  logic pend_for_state;
  logic [7:0] cyc8;
  logic [7:0] cred8;

  always_comb begin
    unique case (state)
      PWR_RUN:  pend_for_state = pend_all;
      PWR_HALT: pend_for_state = pend_all;
      PWR_STOP: pend_for_state = pend_wake;
      default:  pend_for_state = 1'b0;
    endcase
  end

  always_comb begin
    ctl.take = !dma_active && !hc_wr && pend_for_state;
    ctl.wake = ctl.take && (state != PWR_RUN);
    ctl.exec = !dma_active && ((state == PWR_RUN) || ctl.wake);
  end

  if (CRED_W >= 8) begin : g_wide
    assign cyc8   = cpu_step_cycles[7:0];
    assign credit = {{(CRED_W-8){1'b0}}, cred8} |
                    (ctl.exec ? cpu_step_cycles : '0);
  end else begin : g_narrow
    assign cyc8   = {{(8-CRED_W){1'b0}}, cpu_step_cycles};
    assign credit = cred8[CRED_W-1:0];
  end

  assign cred8     = step_credit(dma_active, ctl.exec, state, cyc8);
  assign periph_en = !((state == PWR_STOP) && !ctl.wake);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
#(
  parameter int STOP_BIT = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hc_wr,
  input  logic [7:0] hc_wdata,
  input  logic       wake,
  output pwr_state_e state
);
  pwr_state_e state_nx;

  always_comb begin
    state_nx = state;
    if (hc_wr)     state_nx = write_target(hc_wdata[STOP_BIT]);
    else if (wake) state_nx = PWR_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_RUN;
    else        state <= state_nx;
  end
endmodule

// File: rtl/cpu_power_ctrl.sv
module cpu_power_ctrl
  import pwr_pkg::*;
#(
  parameter int               IRQ_W     = 14,
  parameter int               CRED_W    = 8,
  parameter int               STOP_BIT  = 7,
  parameter logic [IRQ_W-1:0] WAKE_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_wr,
  input  logic [7:0]        hc_wdata,
  output logic [7:0]        hc_rdata,
  input  logic [IRQ_W-1:0]  irq_en,
  input  logic [IRQ_W-1:0]  irq_flag,
  input  logic              dma_active,
  input  logic [CRED_W-1:0] cpu_step_cycles,
  output logic              cpu_clk_en,
  output logic              cpu_irq_take,
  output logic              periph_en,
  output logic [CRED_W-1:0] cycle_credit,
  output logic [1:0]        pwr_state
);
  pwr_state_e state;
  step_ctl_t  ctl;
  logic       pend_all;
  logic       pend_wake;
  logic       wake_evt;

  pwr_wake_detect #(.IRQ_W(IRQ_W), .WAKE_MASK(WAKE_MASK)) u_wake (
    .irq_en   (irq_en),
    .irq_flag (irq_flag),
    .pend_all (pend_all),
    .pend_wake(pend_wake)
  );

  pwr_step_arbiter #(.CRED_W(CRED_W)) u_arb (
    .state          (state),
    .dma_active     (dma_active),
    .hc_wr          (hc_wr),
    .pend_all       (pend_all),
    .pend_wake      (pend_wake),
    .cpu_step_cycles(cpu_step_cycles),
    .ctl            (ctl),
    .credit         (cycle_credit),
    .periph_en      (periph_en)
  );

  assign wake_evt = ctl.wake;

  pwr_state_fsm #(.STOP_BIT(STOP_BIT)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .hc_wr   (hc_wr),
    .hc_wdata(hc_wdata),
    .wake    (wake_evt),
    .state   (state)
  );

  assign cpu_clk_en   = ctl.exec;
  assign cpu_irq_take = ctl.take;
  assign pwr_state    = state;
  assign hc_rdata     = 8'h00;
endmodule

// File: rtl/pwr_ctrl_chk.sv
module pwr_ctrl_chk #(
  parameter int IRQ_W    = 14,
  parameter int CRED_W   = 8,
  parameter int STOP_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hc_wr,
  input logic [7:0]        hc_wdata,
  input logic              dma_active,
  input logic [CRED_W-1:0] cpu_step_cycles,
  input logic              cpu_clk_en,
  input logic              cpu_irq_take,
  input logic              periph_en,
  input logic [CRED_W-1:0] cycle_credit,
  input logic [1:0]        pwr_state,
  input logic              pend_all,
  input logic              wake_evt
);
  // R4
  dma_owns_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_active |-> (!cpu_clk_en && !cpu_irq_take && cycle_credit == '0));

  // R2
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hc_wr |=> (pwr_state == ($past(hc_wdata[STOP_BIT]) ? 2'd2 : 2'd1)));

  // R5
  run_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && !dma_active) |-> (cpu_clk_en && cycle_credit == cpu_step_cycles));

  // R6
  halt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && !dma_active && !pend_all) |-> (!cpu_clk_en && cycle_credit == 1));

  // R8
  stop_paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && !wake_evt) |-> (!periph_en && !cpu_clk_en && cycle_credit == '0));

  // R7
  wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (pwr_state == 2'd0));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hc_wr |-> !cpu_irq_take);

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && !wake_evt && !hc_wr) |=> (pwr_state == 2'd2));
endmodule

bind cpu_power_ctrl pwr_ctrl_chk #(.IRQ_W(IRQ_W), .CRED_W(CRED_W), .STOP_BIT(STOP_BIT)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hc_wr          (hc_wr),
  .hc_wdata       (hc_wdata),
  .dma_active     (dma_active),
  .cpu_step_cycles(cpu_step_cycles),
  .cpu_clk_en     (cpu_clk_en),
  .cpu_irq_take   (cpu_irq_take),
  .periph_en      (periph_en),
  .cycle_credit   (cycle_credit),
  .pwr_state      (pwr_state),
  .pend_all       (pend_all),
  .wake_evt       (wake_evt)
);

// File: tb/tb_cpu_power_ctrl.sv
module tb_cpu_power_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IRQ_W = 4;
  localparam logic [IRQ_W-1:0] MASK = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hc_wr = 1'b0;
  logic [7:0] hc_wdata = 8'h00;
  logic [7:0] hc_rdata;
  logic [IRQ_W-1:0] irq_en = '0, irq_flag = '0;
  logic       dma_active = 1'b0;
  logic [7:0] cpu_step_cycles = 8'd0;
  logic       cpu_clk_en, cpu_irq_take, periph_en;
  logic [7:0] cycle_credit;
  logic [1:0] pwr_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_power_ctrl #(.IRQ_W(IRQ_W), .CRED_W(8), .STOP_BIT(7), .WAKE_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .hc_wr(hc_wr), .hc_wdata(hc_wdata), .hc_rdata(hc_rdata),
    .irq_en(irq_en), .irq_flag(irq_flag), .dma_active(dma_active),
    .cpu_step_cycles(cpu_step_cycles), .cpu_clk_en(cpu_clk_en),
    .cpu_irq_take(cpu_irq_take), .periph_en(periph_en),
    .cycle_credit(cycle_credit), .pwr_state(pwr_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Put the block into a state: write for halt/stop, wake through halt for run
  task automatic set_state(input int s);
    @(negedge clk);
    irq_en = '0; irq_flag = '0; dma_active = 0;
    hc_wr = 1; hc_wdata = (s == 2) ? 8'h80 : 8'h00;
    @(negedge clk);
    hc_wr = 0;
    if (s == 0) begin
      irq_en = 4'h1; irq_flag = 4'h1;
      @(negedge clk);
      irq_en = '0; irq_flag = '0;
    end
    #1 chk("R2 setup state", pwr_state, s);
  endtask

  // One step with model-computed expectations
  task automatic step(input int s, input logic [3:0] ie, input logic [3:0] fl,
                      input logic dma, input logic wr, input logic [7:0] wd,
                      input logic [7:0] cyc);
    logic [3:0] pf;
    logic pend;
    int e_exec, e_take, e_cred, e_per, e_next;
    pf = ie & fl;
    pend = (s == 2) ? |(pf & MASK) : |pf;
    if (dma || wr) pend = 0;
    e_take = pend;
    e_exec = !dma && (s == 0 || pend);
    e_cred = dma ? 0 : e_exec ? cyc : (s == 1) ? 1 : 0;
    e_per  = (s == 2 && !pend) ? 0 : 1;
    e_next = wr ? (wd[7] ? 2 : 1) : pend ? 0 : s;
    @(negedge clk);
    irq_en = ie; irq_flag = fl; dma_active = dma; hc_wr = wr; hc_wdata = wd;
    cpu_step_cycles = cyc;
    #1;
    if (dma) begin
      chk("R4 clk_en", cpu_clk_en, 0); chk("R4 credit", cycle_credit, 0);
      chk("R4 take", cpu_irq_take, 0);
    end else if (wr) begin
      chk("R10 take", cpu_irq_take, 0); chk("R10 clk_en", cpu_clk_en, e_exec);
      chk("R10 credit", cycle_credit, e_cred);
    end else if (s == 0) begin
      chk("R5 clk_en", cpu_clk_en, e_exec); chk("R5 credit", cycle_credit, e_cred);
      chk("R5 take", cpu_irq_take, e_take);
    end else if (s == 1 && !e_take) begin
      chk("R6 clk_en", cpu_clk_en, e_exec); chk("R6 credit", cycle_credit, e_cred);
    end else if (s == 1) begin
      chk("R7 take", cpu_irq_take, e_take); chk("R7 clk_en", cpu_clk_en, e_exec);
      chk("R7 credit", cycle_credit, e_cred);
    end else begin
      chk("R9 take", cpu_irq_take, e_take); chk("R8 clk_en", cpu_clk_en, e_exec);
      chk("R8 credit", cycle_credit, e_cred);
    end
    chk(s == 2 ? "R8 periph_en" : "R1 periph_en", periph_en, e_per);
    @(posedge clk); #1;
    chk(wr ? "R2 next state" : (s == 2 ? "R9 next state" : "R7 next state"),
        pwr_state, e_next);
    hc_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 reset state", pwr_state, 0);
    chk("R1 reset periph_en", periph_en, 1);
    chk("R3 read zero", hc_rdata, 0);

    // Sweep every enable/flag pair in every state, DMA idle and busy
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 2; d++)
        for (int v = 0; v < 256; v++) begin
          set_state(s);
          step(s, v[7:4], v[3:0], d[0], 1'b0, 8'h00, 8'(v ^ 8'h5A));
        end

    // Writes coinciding with pending interrupts, then wake next cycle
    set_state(1);
    step(1, 4'h1, 4'h1, 0, 1, 8'h80, 8'd9);   // R10 halt -> stop despite pend
    step(2, 4'h1, 4'h1, 0, 0, 8'h00, 8'd9);   // wake on following cycle
    set_state(0);
    step(0, 4'hF, 4'hF, 0, 1, 8'h00, 8'd4);   // R10 run write, cpu still runs
    step(1, 4'hF, 4'hF, 0, 0, 8'h00, 8'd4);
    set_state(2);
    step(2, 4'h2, 4'h2, 0, 1, 8'h7F, 8'd3);   // stop -> halt by write
    step(1, 4'h2, 4'h2, 0, 0, 8'h00, 8'd3);   // non-mask source wakes halt
    set_state(0);
    step(0, 4'h0, 4'h0, 1, 1, 8'hFF, 8'd6);   // R2 write during DMA
    step(2, 4'h0, 4'h0, 1, 0, 8'h00, 8'd6);   // R4 DMA holds stop
    chk("R3 read zero later", hc_rdata, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule